// File: doc/BRIEF.md
# Parallel Posit Operand Decoder with Product Sign and Scale

This block is the front stage of a fused posit dot-product datapath. In a single cycle it takes N pairs of vector posits together with one accumulator posit. It splits every operand into a sign, a combined scale and a mantissa. For each pair it also produces the sign and the scale of the product. The mantissa multiply, alignment, accumulation and re-encoding happen in later stages and are not part of this block.

The vector operands share one word size and exponent size. The accumulator has its own word size and exponent size, which may differ from those of the vectors. All operands are decoded by parallel copies of one field decoder. Each decoder two's-complements a negative word and measures the regime run with a leading-zero count. When the run is made of ones, the bits are inverted before the count. A barrel shifter then left-aligns the exponent and fraction bits that remain.

All results are captured in one output register. A result appears one cycle after its input, and the output valid flag marks it.

Top module: `posit_pair_decoder`

## Requirements
- R1: `out_valid` equals `in_valid` as it was one clock edge earlier, and every output field holds the decode of the inputs presented on that edge.
- R2: While `in_valid` is low, every data output keeps its previous value.
- R3: An all-zero word is flagged as zero. A word with only its top bit set is flagged as not-a-real. Both kinds decode to sign 0, scale 0 and mantissa 0. `prod_zero[i]` is set when either operand of pair i is the zero word, and `c_zero` is set when the accumulator word is zero.
- R4: The sign is the top bit of the word. A negative word is negated in two's complement before its fields are read. The scale is k·2^es + e. Here k is −r for a regime run of r zeros and r−1 for a run of r ones. The field e takes the es bits that follow the terminating bit, filled with zeros where the word runs out.
- R5: A mantissa is w−es−1 bits wide. Its MSB is the implicit leading one, and below it follow the w−es−2 fraction bits, left-aligned and zero-filled.
- R6: For each pair, `prod_sign` is the XOR of the two operand signs and `prod_scale` is the sum of the two scales. Each scale lane is a two's-complement field of `scale_w(VEC_W,VEC_ES)+1` bits, and lane i sits at bit offset i times that width.
- R7: When either operand of a pair is zero, that pair's `prod_sign` is 0 and its `prod_scale` is 0.
- R8: `any_nar` is set when at least one of the 2N+1 input words is the not-a-real pattern.
- R9: The accumulator is decoded with `ACC_W` and `ACC_ES`, independently of the vector format, into `c_sign`, `c_scale`, `c_mant` and `c_zero`.
- R10: While reset is asserted, `out_valid` and every data output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input words are valid this cycle |
| a_in | input | N_PAIRS*VEC_W | Left vector operands, lane i at bit i*VEC_W |
| b_in | input | N_PAIRS*VEC_W | Right vector operands, lane i at bit i*VEC_W |
| c_in | input | ACC_W | Accumulator operand |
| out_valid | output | 1 | Registered results are valid |
| prod_sign | output | N_PAIRS | Product sign per pair |
| prod_scale | output | N_PAIRS*(scale_w(VEC_W,VEC_ES)+1) | Product scale per pair, signed |
| prod_zero | output | N_PAIRS | Pair has a zero operand |
| a_mant | output | N_PAIRS*(VEC_W-VEC_ES-1) | Left operand mantissas with hidden bit |
| b_mant | output | N_PAIRS*(VEC_W-VEC_ES-1) | Right operand mantissas with hidden bit |
| c_sign | output | 1 | Accumulator sign |
| c_scale | output | scale_w(ACC_W,ACC_ES) | Accumulator scale, signed |
| c_mant | output | ACC_W-ACC_ES-1 | Accumulator mantissa with hidden bit |
| c_zero | output | 1 | Accumulator is zero |
| any_nar | output | 1 | Some operand is not-a-real |

## Verification
The assertions assume that `in_valid` is held low while reset is asserted. They also assume that every input word may carry any bit pattern, the zero and not-a-real codes included. The stimulus keeps `in_valid` low through reset. It then walks every one of the 256 eight-bit codes through a lane of two instances at once, one with es 1 and one with es 0. Directed words (zero, not-a-real, the largest and smallest magnitudes, negatives) and seeded random words fill the remaining lanes and the accumulator. Each output is compared with a behavioural decoder in the bench.

// File: rtl/posdec_pkg.sv
package posdec_pkg;
    // width of a signed scale field for a w-bit posit with es exponent bits
    function automatic int scale_w(input int w, input int es);
        return $clog2(w) + es + 2;
    endfunction

    // mantissa width: hidden one plus w-es-2 fraction bits
    function automatic int mant_w(input int w, input int es);
        return w - es - 1;
    endfunction
endpackage

// File: rtl/lead_zero_count.sv
module lead_zero_count #(
    parameter int W = 7,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    always_comb begin
        cnt = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                cnt = CW'(W - 1 - i);
            end
        end
    end
endmodule

// File: rtl/stage_shifter.sv
module stage_shifter #(
    parameter int W   = 6,
    parameter int SHW = 3
) (
    input  logic [W-1:0]   din,
    input  logic [SHW-1:0] amt,
    output logic [W-1:0]   dout
);
    logic [W-1:0] stage [SHW+1];

    assign stage[0] = din;

    for (genvar j = 0; j < SHW; j++) begin : g_stage
        assign stage[j+1] = amt[j] ? (stage[j] << (1 << j)) : stage[j];
    end

    assign dout = stage[SHW];
endmodule

// File: rtl/posit_field_decoder.sv
module posit_field_decoder
    import posdec_pkg::*;
#(
    parameter int W  = 8,
    parameter int ES = 1,
    localparam int BW = W - 1,
    localparam int RW = W - 2,
    localparam int CW = $clog2(W),
    localparam int SW = scale_w(W, ES),
    localparam int FW = W - ES - 2,
    localparam int MW = mant_w(W, ES)
) (
    input  logic                 word,
    input  logic [W-1:0]         bits,
    output logic                 sign_o,
    output logic signed [SW-1:0] scale_o,
    output logic [MW-1:0]        mant_o,
    output logic                 zero_o,
    output logic                 nar_o
);
    logic                 special;
    logic [BW-1:0]        body;
    logic [BW-1:0]        probe;
    logic [CW-1:0]        run;
    logic [RW-1:0]        rest;
    logic signed [SW-1:0] run_s;
    logic signed [SW-1:0] kval;
    logic signed [SW-1:0] raw_scale;
    logic [FW-1:0]        frac;
    logic                 unused_word;

    assign unused_word = word;

    // both special codes have every bit below the sign cleared
    assign special = (bits[BW-1:0] == '0);
    assign zero_o  = special & ~bits[W-1];
    assign nar_o   = special & bits[W-1];

    // magnitude body: low bits of the two's-complement negation when negative
    assign body  = bits[W-1] ? (~bits[BW-1:0] + BW'(1)) : bits[BW-1:0];
    // a run of ones is turned into a run of zeros for the counter
    assign probe = body[BW-1] ? ~body : body;

    lead_zero_count #(.W(BW)) u_run (
        .vec(probe),
        .cnt(run)
    );

    // the run's first bit sits above body[RW-1:0]; shifting by the run
    // length drops the rest of the run and the terminating bit
    stage_shifter #(.W(RW), .SHW(CW)) u_align (
        .din(body[RW-1:0]),
        .amt(run),
        .dout(rest)
    );

    assign run_s = $signed(SW'(run));
    assign kval  = body[BW-1] ? (run_s - SW'(1)) : -run_s;

    if (ES > 0) begin : g_exp
        logic [ES-1:0] ebits;
        assign ebits     = rest[RW-1 -: ES];
        assign raw_scale = (kval <<< ES) + $signed({{(SW-ES){1'b0}}, ebits});
        assign frac      = rest[FW-1:0];
    end else begin : g_noexp
        assign raw_scale = kval;
        assign frac      = rest;
    end

    assign sign_o  = special ? 1'b0 : bits[W-1];
    assign scale_o = special ? '0 : raw_scale;
    assign mant_o  = special ? '0 : {1'b1, frac};
endmodule

// File: rtl/posit_pair_decoder.sv
module posit_pair_decoder
    import posdec_pkg::*;
#(
    parameter int N_PAIRS = 4,
    parameter int VEC_W   = 8,
    parameter int VEC_ES  = 1,
    parameter int ACC_W   = 16,
    parameter int ACC_ES  = 1,
    localparam int VSW = scale_w(VEC_W, VEC_ES),
    localparam int PSW = VSW + 1,
    localparam int VMW = mant_w(VEC_W, VEC_ES),
    localparam int ASW = scale_w(ACC_W, ACC_ES),
    localparam int AMW = mant_w(ACC_W, ACC_ES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [N_PAIRS*VEC_W-1:0] a_in,
    input  logic [N_PAIRS*VEC_W-1:0] b_in,
    input  logic [ACC_W-1:0]       c_in,
    output logic                   out_valid,
    output logic [N_PAIRS-1:0]     prod_sign,
    output logic [N_PAIRS*PSW-1:0] prod_scale,
    output logic [N_PAIRS-1:0]     prod_zero,
    output logic [N_PAIRS*VMW-1:0] a_mant,
    output logic [N_PAIRS*VMW-1:0] b_mant,
    output logic                   c_sign,
    output logic [ASW-1:0]         c_scale,
    output logic [AMW-1:0]         c_mant,
    output logic                   c_zero,
    output logic                   any_nar
);
    logic [N_PAIRS-1:0]     psign_d;
    logic [N_PAIRS*PSW-1:0] pscale_d;
    logic [N_PAIRS-1:0]     pzero_d;
    logic [N_PAIRS*VMW-1:0] amant_d;
    logic [N_PAIRS*VMW-1:0] bmant_d;
    logic [2*N_PAIRS-1:0]   vec_nar;

    logic                   c_sign_d;
    logic signed [ASW-1:0]  c_scale_d;
    logic [AMW-1:0]         c_mant_d;
    logic                   c_zero_d;
    logic                   c_nar_d;
    logic                   nar_d;

    for (genvar i = 0; i < N_PAIRS; i++) begin : g_pair
        logic                  a_s, b_s, a_z, b_z;
        logic signed [VSW-1:0] a_e, b_e;
        logic signed [PSW-1:0] sum_e;
        logic                  pz;

        posit_field_decoder #(.W(VEC_W), .ES(VEC_ES)) u_dec_a (
            .word(in_valid),
            .bits(a_in[i*VEC_W +: VEC_W]),
            .sign_o(a_s),
            .scale_o(a_e),
            .mant_o(amant_d[i*VMW +: VMW]),
            .zero_o(a_z),
            .nar_o(vec_nar[2*i])
        );

        posit_field_decoder #(.W(VEC_W), .ES(VEC_ES)) u_dec_b (
            .word(in_valid),
            .bits(b_in[i*VEC_W +: VEC_W]),
            .sign_o(b_s),
            .scale_o(b_e),
            .mant_o(bmant_d[i*VMW +: VMW]),
            .zero_o(b_z),
            .nar_o(vec_nar[2*i+1])
        );

        assign pz    = a_z | b_z;
        assign sum_e = $signed({a_e[VSW-1], a_e}) + $signed({b_e[VSW-1], b_e});

        assign pzero_d[i]             = pz;
        assign psign_d[i]             = pz ? 1'b0 : (a_s ^ b_s);
        assign pscale_d[i*PSW +: PSW] = pz ? '0 : sum_e;
    end

    posit_field_decoder #(.W(ACC_W), .ES(ACC_ES)) u_dec_c (
        .word(in_valid),
        .bits(c_in),
        .sign_o(c_sign_d),
        .scale_o(c_scale_d),
        .mant_o(c_mant_d),
        .zero_o(c_zero_d),
        .nar_o(c_nar_d)
    );

    assign nar_d = (|vec_nar) | c_nar_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            prod_sign  <= '0;
            prod_scale <= '0;
            prod_zero  <= '0;
            a_mant     <= '0;
            b_mant     <= '0;
            c_sign     <= 1'b0;
            c_scale    <= '0;
            c_mant     <= '0;
            c_zero     <= 1'b0;
            any_nar    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                prod_sign  <= psign_d;
                prod_scale <= pscale_d;
                prod_zero  <= pzero_d;
                a_mant     <= amant_d;
                b_mant     <= bmant_d;
                c_sign     <= c_sign_d;
                c_scale    <= c_scale_d;
                c_mant     <= c_mant_d;
                c_zero     <= c_zero_d;
                any_nar    <= nar_d;
            end
        end
    end
endmodule

// File: rtl/posit_pair_decoder_chk.sv
module posit_pair_decoder_chk #(
    parameter int N_PAIRS = 4,
    parameter int VEC_W   = 8,
    parameter int ACC_W   = 16,
    parameter int PSW     = 7,
    parameter int VMW     = 6
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic [N_PAIRS*VEC_W-1:0] a_in,
    input logic [N_PAIRS*VEC_W-1:0] b_in,
    input logic [ACC_W-1:0]       c_in,
    input logic                   out_valid,
    input logic [N_PAIRS-1:0]     prod_sign,
    input logic [N_PAIRS*PSW-1:0] prod_scale,
    input logic [N_PAIRS-1:0]     prod_zero,
    input logic [N_PAIRS*VMW-1:0] a_mant,
    input logic [N_PAIRS*VMW-1:0] b_mant,
    input logic                   any_nar
);
    localparam logic [VEC_W-1:0] VEC_NAR = {1'b1, {(VEC_W-1){1'b0}}};
    localparam logic [ACC_W-1:0] ACC_NAR = {1'b1, {(ACC_W-1){1'b0}}};

    logic                armed;
    logic                nar_seen;
    logic [N_PAIRS-1:0]  zero_seen;

    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    always_comb begin
        nar_seen = (c_in == ACC_NAR);
        for (int i = 0; i < N_PAIRS; i++) begin
            zero_seen[i] = (a_in[i*VEC_W +: VEC_W] == '0) || (b_in[i*VEC_W +: VEC_W] == '0);
            if (a_in[i*VEC_W +: VEC_W] == VEC_NAR || b_in[i*VEC_W +: VEC_W] == VEC_NAR) begin
                nar_seen = 1'b1;
            end
        end
    end

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (out_valid == $past(in_valid)));

    // R2
    hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(in_valid)) |-> ($stable(prod_scale) && $stable(prod_sign)
            && $stable(a_mant) && $stable(b_mant) && $stable(any_nar)));

    // R8
    nar_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && out_valid) |-> (any_nar == $past(nar_seen)));

    for (genvar i = 0; i < N_PAIRS; i++) begin : g_lane
        // R3
        zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && out_valid) |-> (prod_zero[i] == $past(zero_seen[i])));

        // R7
        zero_product_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && prod_zero[i]) |-> (!prod_sign[i] && prod_scale[i*PSW +: PSW] == '0));
    end
endmodule

bind posit_pair_decoder posit_pair_decoder_chk #(
    .N_PAIRS(N_PAIRS),
    .VEC_W(VEC_W),
    .ACC_W(ACC_W),
    .PSW(PSW),
    .VMW(VMW)
) i_chk (
    .clk(clk),
    .rst_n(rst_n),
    .in_valid(in_valid),
    .a_in(a_in),
    .b_in(b_in),
    .c_in(c_in),
    .out_valid(out_valid),
    .prod_sign(prod_sign),
    .prod_scale(prod_scale),
    .prod_zero(prod_zero),
    .a_mant(a_mant),
    .b_mant(b_mant),
    .any_nar(any_nar)
);

// File: tb/test_posit_pair_decoder.sv
module test_posit_pair_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int NP   = 4;
    localparam int PSW1 = 7;
    localparam int VMW1 = 6;
    localparam int PSW0 = 6;
    localparam int VMW0 = 7;
    localparam int ASW  = 7;
    localparam int AMW  = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [NP*8-1:0] a_in = '0;
    logic [NP*8-1:0] b_in = '0;
    logic [15:0]     c_in = '0;

    logic              ov1, ov0;
    logic [NP-1:0]     ps1, ps0, pz1, pz0;
    logic [NP*PSW1-1:0] psc1;
    logic [NP*PSW0-1:0] psc0;
    logic [NP*VMW1-1:0] am1, bm1;
    logic [NP*VMW0-1:0] am0, bm0;
    logic              cs1, cs0, cz1, cz0, nar1, nar0;
    logic [ASW-1:0]    csc1, csc0;
    logic [AMW-1:0]    cm1, cm0;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    int av[NP], bv[NP], cv;
    int la[NP], lb[NP], lc;

    always #(CLK_PERIOD/2) clk = ~clk;

    posit_pair_decoder #(.N_PAIRS(NP), .VEC_W(8), .VEC_ES(1), .ACC_W(16), .ACC_ES(1)) i_posit_pair_decoder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .a_in(a_in), .b_in(b_in), .c_in(c_in),
        .out_valid(ov1), .prod_sign(ps1), .prod_scale(psc1), .prod_zero(pz1),
        .a_mant(am1), .b_mant(bm1), .c_sign(cs1), .c_scale(csc1), .c_mant(cm1),
        .c_zero(cz1), .any_nar(nar1)
    );

    posit_pair_decoder #(.N_PAIRS(NP), .VEC_W(8), .VEC_ES(0), .ACC_W(16), .ACC_ES(1)) i_posit_pair_decoder_es0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .a_in(a_in), .b_in(b_in), .c_in(c_in),
        .out_valid(ov0), .prod_sign(ps0), .prod_scale(psc0), .prod_zero(pz0),
        .a_mant(am0), .b_mant(bm0), .c_sign(cs0), .c_scale(csc0), .c_mant(cm0),
        .c_zero(cz0), .any_nar(nar0)
    );

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000 && !done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog got=%0d exp=%0d", cyc, 0);
            summary();
            $finish;
        end
    end

    task automatic chk(string req, string what, longint got, longint exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s got=%0d exp=%0d", req, what, got, exp);
        end
    endtask

    function automatic int sx(longint v, int w);
        if (v >= (longint'(1) << (w - 1))) return int'(v - (longint'(1) << w));
        return int'(v);
    endfunction

    // behavioural posit decode
    task automatic ref_dec(input int x, input int w, input int es,
                           output int sg, output int sc, output int mt,
                           output bit zr, output bit nr);
        int m, rb, run, pos, k, e, f, fw;
        zr = (x == 0);
        nr = (x == (1 << (w - 1)));
        sg = 0; sc = 0; mt = 0;
        if (zr || nr) return;
        sg = (x >> (w - 1)) & 1;
        m = sg ? ((1 << w) - x) : x;
        rb = (m >> (w - 2)) & 1;
        run = 0;
        pos = w - 2;
        while (pos >= 0 && ((m >> pos) & 1) == rb) begin
            run++;
            pos--;
        end
        pos--;
        k = rb ? run - 1 : -run;
        e = 0;
        for (int j = 0; j < es; j++) begin
            e = (e << 1) | ((pos >= 0) ? ((m >> pos) & 1) : 0);
            pos--;
        end
        fw = w - es - 2;
        f = 0;
        for (int j = 0; j < fw; j++) begin
            f = (f << 1) | ((pos >= 0) ? ((m >> pos) & 1) : 0);
            pos--;
        end
        mt = (1 << fw) | f;
        sc = k * (1 << es) + e;
    endtask

    task automatic check_inst(string nm, int es, int psw, int mw, logic ov,
                              logic [63:0] ps, logic [63:0] psc, logic [63:0] pz,
                              logic [63:0] am, logic [63:0] bm, logic nar);
        int sa, ca, ma, sb, cb, mb, ec;
        bit za, na, zb, nb, anyn;
        bit ze, ne;
        int dsg, dsc, dmt;
        chk("R1", {nm, " out_valid"}, ov, 1);
        ref_dec(lc, 16, 1, dsg, dsc, dmt, ze, ne);
        anyn = ne;
        for (int i = 0; i < NP; i++) begin
            ref_dec(la[i], 8, es, sa, ca, ma, za, na);
            ref_dec(lb[i], 8, es, sb, cb, mb, zb, nb);
            anyn = anyn | na | nb;
            chk("R3", {nm, " prod_zero"}, (pz >> i) & 1, za | zb);
            if (za || zb) begin
                chk("R7", {nm, " zero prod_sign"}, (ps >> i) & 1, 0);
                chk("R7", {nm, " zero prod_scale"}, sx((psc >> (i*psw)) & ((64'd1 << psw) - 1), psw), 0);
            end else begin
                ec = ca + cb;
                chk("R6", {nm, " prod_sign"}, (ps >> i) & 1, sa ^ sb);
                chk("R6", {nm, " prod_scale"}, sx((psc >> (i*psw)) & ((64'd1 << psw) - 1), psw), ec);
            end
            chk("R5", {nm, " a_mant"}, (am >> (i*mw)) & ((64'd1 << mw) - 1), ma);
            chk("R5", {nm, " b_mant"}, (bm >> (i*mw)) & ((64'd1 << mw) - 1), mb);
        end
        chk("R8", {nm, " any_nar"}, nar, anyn);
    endtask

    task automatic check_acc();
        int sg, sc, mt;
        bit zr, nr;
        ref_dec(lc, 16, 1, sg, sc, mt, zr, nr);
        chk("R4", "c_sign", cs1, sg);
        chk("R4", "c_scale", sx(csc1, ASW), sc);
        chk("R9", "c_mant", cm1, mt);
        chk("R3", "c_zero", cz1, zr);
        chk("R9", "c_scale es0 instance", sx(csc0, ASW), sc);
    endtask

    task automatic apply(bit v);
        @(negedge clk);
        for (int i = 0; i < NP; i++) begin
            a_in[i*8 +: 8] = 8'(av[i]);
            b_in[i*8 +: 8] = 8'(bv[i]);
        end
        c_in = 16'(cv);
        in_valid = v;
        if (v) begin
            for (int i = 0; i < NP; i++) begin
                la[i] = av[i] & 255;
                lb[i] = bv[i] & 255;
            end
            lc = cv & 16'hFFFF;
        end
        @(negedge clk);
    endtask

    task automatic run_vec();
        apply(1'b1);
        check_inst("es1", 1, PSW1, VMW1, ov1, 64'(ps1), 64'(psc1), 64'(pz1), 64'(am1), 64'(bm1), nar1);
        check_inst("es0", 0, PSW0, VMW0, ov0, 64'(ps0), 64'(psc0), 64'(pz0), 64'(am0), 64'(bm0), nar0);
        check_acc();
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < NP; i++) begin
            av[i] = 0; bv[i] = 0; la[i] = 0; lb[i] = 0;
        end
        cv = 0; lc = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        chk("R10", "out_valid in reset", ov1, 0);
        chk("R10", "prod_scale in reset", psc1, 0);
        chk("R10", "c_mant in reset", cm1, 0);
        chk("R10", "a_mant in reset", am1, 0);
        rst_n = 1'b1;

        // every 8-bit code in lane 0 against the value one, for both es
        for (int v = 0; v < 256; v++) begin
            av[0] = v;          bv[0] = 8'h40;
            av[1] = v ^ 8'hFF;  bv[1] = $urandom & 255;
            av[2] = $urandom & 255; bv[2] = v;
            av[3] = $urandom & 255; bv[3] = $urandom & 255;
            cv = $urandom & 16'hFFFF;
            run_vec();
        end

        // directed corners
        for (int i = 0; i < NP; i++) begin av[i] = 0; bv[i] = 0; end
        cv = 0;
        run_vec();
        for (int i = 0; i < NP; i++) begin av[i] = 8'h41; bv[i] = 8'h3F; end
        cv = 16'h8000;
        run_vec();
        av[0] = 8'h7F; bv[0] = 8'h7F;
        av[1] = 8'h01; bv[1] = 8'h01;
        av[2] = 8'hFF; bv[2] = 8'h81;
        av[3] = 8'h80; bv[3] = 8'h40;
        cv = 16'h7FFF;
        run_vec();
        av[3] = 8'h33; bv[3] = 8'hC4;
        cv = 16'h0001;
        run_vec();

        // random mix
        for (int n = 0; n < 300; n++) begin
            for (int i = 0; i < NP; i++) begin
                av[i] = $urandom & 255;
                bv[i] = $urandom & 255;
            end
            cv = $urandom & 16'hFFFF;
            run_vec();
        end

        // R2: inputs change with in_valid low, outputs keep the last result
        for (int i = 0; i < NP; i++) begin av[i] = 8'h80; bv[i] = 0; end
        cv = 16'h8000;
        apply(1'b0);
        chk("R1", "out_valid after idle", ov1, 0);
        apply(1'b0);
        chk("R2", "any_nar held", nar1, 0);
        check_inst("es1 hold R2", 1, PSW1, VMW1, 1'b1, 64'(ps1), 64'(psc1), 64'(pz1), 64'(am1), 64'(bm1), nar1);
        check_acc();

        done = 1;
        summary();
        $finish;
    end
endmodule